// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Strobe

This block takes one result of a converter, held as a set of BCD digits, and time-shares it over a single 4-bit data bus. A group of active-high select lines marks which digit is on the bus. The most significant digit comes first, then each lower digit in turn. After the least significant digit the pass starts again at the top, so a display or a downstream latch can refresh continuously.

A single-cycle conversion-done pulse captures the digits and the overrange flag. It then starts a pass in which an active-low strobe falls once in the middle of every digit slot. A processor, UART or external latch can take each digit on that edge. Later passes repeat the selects and data with no strobe until the next result arrives. An overranged result shows all-zero data. The select lines go dark right after the last strobe and stay dark until a reference-integrate start input releases them, so the display blinks. The lead (most significant) slot is one clock longer than the others, and its strobe sits one clock later.

Top module: `adsc_digit_scanner`

## Requirements
- R1: After reset and until the first conversion-done pulse, all select lines and all data bits are 0 and the strobe is 1.
- R2: The cycle after done_i is sampled high, select bit NUM_DIGITS-1 (the most significant digit) is high. Each later slot moves to the next lower select bit, down to bit 0, and never more than one select bit is high.
- R3: The most significant slot lasts SLOT_CLKS+LEAD_EXTRA cycles (201) and every other slot lasts SLOT_CLKS cycles (200). After bit 0 the scan returns to the most significant slot and repeats without end.
- R4: In a strobed pass the strobe is low for exactly one cycle per slot. Counting a slot's first selected cycle as 0, this is cycle STROBE_OFS+LEAD_EXTRA (101) in the most significant slot and cycle STROBE_OFS (100) in the others.
- R5: Only the first pass after a done pulse carries strobes, five for five digits. All later passes have the strobe held high.
- R6: Digit k is digits_i[4k+3:4k], with k=0 the least significant, and bit 3 carries weight 8. bcd_o equals the digit captured at the done pulse for the selected slot, and it changes in the same cycle as the select lines. Changes of digits_i or ovr_i between done pulses have no effect.
- R7: With ovr_i captured high, bcd_o is 0 for the whole result. In the strobed pass, from the cycle after the least significant strobe, all select lines are low and stay low. The cycle after a refint_i pulse, the scan resumes at the most significant slot with no strobes.
- R8: refint_i has no effect unless the selects are blanked by an overrange.
- R9: A done pulse at any time, including mid-slot or during blanking, restarts at the most significant slot with fresh strobes and new data. When done_i and refint_i are high together, the done pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scanner clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 1 | One-cycle pulse: a new result is ready |
| digits_i | input | NUM_DIGITS*4 | BCD digits of the result, digit 0 in the low nibble |
| ovr_i | input | 1 | Overrange flag of the result, sampled with done_i |
| refint_i | input | 1 | Reference-integrate start; releases overrange blanking |
| sel_o | output | NUM_DIGITS | Active-high digit select, bit NUM_DIGITS-1 is the most significant digit |
| bcd_o | output | 4 | Positive-true BCD data of the selected digit |
| strobe_n_o | output | 1 | Active-low one-cycle data strobe |

## Verification
A slot counter that is off by even one count moves every later select edge and every strobe by that many cycles. This shows up at the ports within one slot, at most 201 cycles. A pass flag in the wrong state adds or drops a strobe within the next pass of 1001 cycles. A wrong digit pointer puts the wrong select bit or nibble on the bus at the very next slot boundary. A blanking flag that will not clear leaves the select lines dark past the cycle after refint_i, and one that sets too early cuts off the last strobe. The bench therefore compares every change of the full output word against an expected cycle stamp, so any of these faults shows as a wrong time or a wrong value.

// File: rtl/adsc_pkg.sv
package adsc_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/adsc_slot_timer.sv
module adsc_slot_timer
#(
   parameter int SLOT_CLKS  = 200,
   parameter int LEAD_EXTRA = 1,
   parameter int STROBE_OFS = 100
)
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic lead_i,
   output logic last_o,
   output logic mid_o
);
   localparam int LEAD_LEN = SLOT_CLKS + LEAD_EXTRA;
   localparam int CNT_W    = $clog2(LEAD_LEN);
   localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_LEN - 1);
   localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(SLOT_CLKS - 1);
   localparam logic [CNT_W-1:0] LEAD_MID  = CNT_W'(STROBE_OFS + LEAD_EXTRA);
   localparam logic [CNT_W-1:0] BODY_MID  = CNT_W'(STROBE_OFS);

   logic [CNT_W-1:0] cnt_q;

   // slot end and strobe point depend on whether the lead slot is running
   assign last_o = lead_i ? (cnt_q == LEAD_LAST) : (cnt_q == BODY_LAST);
   assign mid_o  = lead_i ? (cnt_q == LEAD_MID)  : (cnt_q == BODY_MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         if (last_o) cnt_q <= '0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/adsc_digit_ptr.sv
module adsc_digit_ptr
#(
   parameter int NUM_DIGITS = 5,
   parameter int IDX_W      = $clog2(NUM_DIGITS)
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             rewind_i,
   input  logic             drop_i,
   input  logic             step_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             pass_o,
   output logic             lead_o,
   output logic             tail_o
);
   localparam logic [IDX_W-1:0] LEAD_IDX = IDX_W'(NUM_DIGITS - 1);

   logic [IDX_W-1:0] idx_q;
   logic             pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= LEAD_IDX;
         pass_q <= 1'b0;
      end else if (load_i) begin
         idx_q  <= LEAD_IDX;
         pass_q <= 1'b1;
      end else if (rewind_i) begin
         idx_q  <= LEAD_IDX;
         pass_q <= 1'b0;
      end else if (drop_i) begin
         pass_q <= 1'b0;
      end else if (step_i) begin
         if (idx_q == '0) begin
            idx_q  <= LEAD_IDX;
            pass_q <= 1'b0;
         end else begin
            idx_q  <= idx_q - 1'b1;
         end
      end
   end

   assign idx_o  = idx_q;
   assign pass_o = pass_q;
   assign lead_o = (idx_q == LEAD_IDX);
   assign tail_o = (idx_q == '0);
endmodule

// File: rtl/adsc_drive_mux.sv
module adsc_drive_mux
   import adsc_pkg::*;
#(
   parameter int NUM_DIGITS = 5,
   parameter int IDX_W      = $clog2(NUM_DIGITS)
)
(
   input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic                        show_i,
   input  logic                        zero_i,
   input  logic                        strobe_i,
   output logic [NUM_DIGITS-1:0]       sel_o,
   output logic [BCD_W-1:0]            bcd_o,
   output logic                        strobe_n_o
);
   bcd_t masked [NUM_DIGITS];
   bcd_t acc;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      assign sel_o[k]  = show_i & (idx_i == IDX_W'(k));
      assign masked[k] = sel_o[k] ? digits_i[k*BCD_W +: BCD_W] : '0;
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < NUM_DIGITS; k++) acc = acc | masked[k];
   end

   assign bcd_o      = zero_i ? '0 : acc;
   assign strobe_n_o = ~(show_i & strobe_i);
endmodule

// File: rtl/adsc_digit_scanner.sv
module adsc_digit_scanner
   import adsc_pkg::*;
#(
   parameter int NUM_DIGITS = 5,
   parameter int SLOT_CLKS  = 200,
   parameter int LEAD_EXTRA = 1,
   parameter int STROBE_OFS = 100
)
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        done_i,
   input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
   input  logic                        ovr_i,
   input  logic                        refint_i,
   output logic [NUM_DIGITS-1:0]       sel_o,
   output logic [BCD_W-1:0]            bcd_o,
   output logic                        strobe_n_o
);
   localparam int IDX_W = $clog2(NUM_DIGITS);

   initial begin
      if (NUM_DIGITS < 2)          $error("NUM_DIGITS must be at least 2");
      if (SLOT_CLKS < 2)           $error("SLOT_CLKS must be at least 2");
      if (LEAD_EXTRA < 0)          $error("LEAD_EXTRA must not be negative");
      if (STROBE_OFS >= SLOT_CLKS) $error("STROBE_OFS must fall inside a slot");
   end

   logic                        active_q, blank_q, ovr_q;
   logic [NUM_DIGITS*BCD_W-1:0] data_q;
   logic [IDX_W-1:0]            idx;
   logic slot_last, mid_hit, strobe_pass, lead_slot, tail_slot;
   logic run, resume, enter_blank, step;

   assign run         = active_q & ~blank_q;
   assign resume      = ~done_i & blank_q & refint_i;
   // overranged results go dark right after the least significant strobe
   assign enter_blank = ~done_i & run & strobe_pass & ovr_q & tail_slot & mid_hit;
   assign step        = ~done_i & run & slot_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         blank_q  <= 1'b0;
         ovr_q    <= 1'b0;
         data_q   <= '0;
      end else if (done_i) begin
         active_q <= 1'b1;
         blank_q  <= 1'b0;
         ovr_q    <= ovr_i;
         data_q   <= digits_i;
      end else if (resume) begin
         blank_q  <= 1'b0;
      end else if (enter_blank) begin
         blank_q  <= 1'b1;
      end
   end

   adsc_slot_timer #(
      .SLOT_CLKS (SLOT_CLKS),
      .LEAD_EXTRA(LEAD_EXTRA),
      .STROBE_OFS(STROBE_OFS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (done_i | resume),
      .run_i (run),
      .lead_i(lead_slot),
      .last_o(slot_last),
      .mid_o (mid_hit)
   );

   adsc_digit_ptr #(
      .NUM_DIGITS(NUM_DIGITS),
      .IDX_W     (IDX_W)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (done_i),
      .rewind_i(resume),
      .drop_i  (enter_blank),
      .step_i  (step),
      .idx_o   (idx),
      .pass_o  (strobe_pass),
      .lead_o  (lead_slot),
      .tail_o  (tail_slot)
   );

   adsc_drive_mux #(
      .NUM_DIGITS(NUM_DIGITS),
      .IDX_W     (IDX_W)
   ) u_mux (
      .digits_i  (data_q),
      .idx_i     (idx),
      .show_i    (run),
      .zero_i    (ovr_q),
      .strobe_i  (strobe_pass & mid_hit),
      .sel_o     (sel_o),
      .bcd_o     (bcd_o),
      .strobe_n_o(strobe_n_o)
   );
endmodule

// File: rtl/adsc_scan_checker.sv
module adsc_scan_checker
#(
   parameter int NUM_DIGITS = 5
)
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  done_i,
   input logic                  refint_i,
   input logic                  blank_q,
   input logic [NUM_DIGITS-1:0] sel_o,
   input logic [3:0]            bcd_o,
   input logic                  strobe_n_o
);
   localparam logic [NUM_DIGITS-1:0] MSD_SEL = {1'b1, {(NUM_DIGITS-1){1'b0}}};

   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n_o |=> strobe_n_o);

   p_strobe_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n_o |-> (sel_o != '0));

   p_dark_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o == '0) |-> (bcd_o == 4'h0 && strobe_n_o));

   p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_q && !done_i && !refint_i) |=> (sel_o == '0));

   p_resume_msd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_q && refint_i && !done_i) |=> (sel_o == MSD_SEL && strobe_n_o));

   p_restart_msd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (sel_o == MSD_SEL));
endmodule

bind adsc_digit_scanner adsc_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) u_scan_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done_i    (done_i),
   .refint_i  (refint_i),
   .blank_q   (blank_q),
   .sel_o     (sel_o),
   .bcd_o     (bcd_o),
   .strobe_n_o(strobe_n_o)
);

// File: tb/tb_adsc_digit_scanner.sv
module tb_adsc_digit_scanner;
   localparam int P   = 1001;          // one full pass: 201 + 4*200
   localparam int BIG = 32'h7fffffff;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done_i = 1'b0;
   logic [19:0] digits_i = '0;
   logic        ovr_i = 1'b0;
   logic        refint_i = 1'b0;
   logic [4:0]  sel_o;
   logic [3:0]  bcd_o;
   logic        strobe_n_o;

   always #2 clk = ~clk;

   adsc_digit_scanner dut (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .digits_i(digits_i),
      .ovr_i(ovr_i), .refint_i(refint_i),
      .sel_o(sel_o), .bcd_o(bcd_o), .strobe_n_o(strobe_n_o)
   );

   typedef struct {
      int         stamp;
      logic [4:0] sel;
      logic [3:0] bcd;
      logic       sn;
      string      tag;
   } ev_t;

   ev_t        exp_q[$];
   ev_t        mon_ev;
   int         checks = 0;
   int         errors = 0;
   int         ccount = 0;
   bit         mon_en = 1'b0;
   logic [9:0] last_tup = 10'b0000000001;
   logic [9:0] prev_tup = 10'b0000000001;
   logic [9:0] cur_tup;

   always @(posedge clk) ccount <= ccount + 1;

   task automatic push_ev(int st, logic [4:0] s, logic [3:0] b, logic n, string tag);
      ev_t e;
      logic [9:0] tup;
      tup = {s, b, n};
      if (tup == last_tup) return;
      e.stamp = st; e.sel = s; e.bcd = b; e.sn = n; e.tag = tag;
      exp_q.push_back(e);
      last_tup = tup;
   endtask

   // expected output changes of one pass starting at stamp s, kept below lim
   task automatic gen_pass(int s, logic [19:0] d, bit strb, bit ovr, int lim, string tag);
      int t;
      t = s;
      for (int k = 4; k >= 0; k--) begin
         int         len;
         int         off;
         logic [4:0] sv;
         logic [3:0] b;
         len = (k == 4) ? 201 : 200;
         off = (k == 4) ? 101 : 100;
         sv  = 5'(1 << k);
         b   = ovr ? 4'h0 : d[k*4 +: 4];
         if (t < lim) push_ev(t, sv, b, 1'b1, tag);
         if (strb) begin
            if (t + off < lim) push_ev(t + off, sv, b, 1'b0, tag);
            if (ovr && k == 0) begin
               if (t + off + 1 < lim) push_ev(t + off + 1, 5'b0, 4'h0, 1'b1, tag);
            end else if (t + off + 1 < lim) begin
               push_ev(t + off + 1, sv, b, 1'b1, tag);
            end
         end
         t += len;
      end
   endtask

   // monitor: every change of the output word must match the queue head
   always @(negedge clk) begin
      if (mon_en) begin
         cur_tup = {sel_o, bcd_o, strobe_n_o};
         if (cur_tup !== prev_tup) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R8 unexpected change at %0d: got %h expected %h",
                        ccount, cur_tup, prev_tup);
            end else begin
               mon_ev = exp_q.pop_front();
               if (mon_ev.stamp != ccount || cur_tup !== {mon_ev.sel, mon_ev.bcd, mon_ev.sn}) begin
                  errors++;
                  $display("FAIL %s at %0d: got %h expected %h at %0d", mon_ev.tag,
                           ccount, cur_tup, {mon_ev.sel, mon_ev.bcd, mon_ev.sn}, mon_ev.stamp);
               end
            end
            prev_tup = cur_tup;
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [9:0] got, logic [9:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, expv);
      end
   endtask

   task automatic wait_stamp(int st);
      while (ccount < st) @(negedge clk);
   endtask

   task automatic pulse(bit d, bit r, logic [19:0] data, bit ov);
      done_i   = d;
      refint_i = r;
      digits_i = data;
      ovr_i    = ov;
      @(negedge clk);
      done_i   = 1'b0;
      refint_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int sA, sB, sC, sR, sE, sF, n1, n2, n3, n4, n5;
      logic [19:0] da, db, dc, de, df;
      da = 20'h12345; db = 20'h90817; dc = 20'h55555; de = 20'h31415; df = 20'h24680;

      repeat (5) @(negedge clk);
      chk({sel_o, bcd_o, strobe_n_o} === 10'b1, "R1 in reset", {sel_o, bcd_o, strobe_n_o}, 10'b1);
      rst_n = 1'b1;
      mon_en = 1'b1;
      repeat (30) @(negedge clk);
      chk({sel_o, bcd_o, strobe_n_o} === 10'b1, "R1 idle before done", {sel_o, bcd_o, strobe_n_o}, 10'b1);

      // A: strobed pass, two plain passes, restart mid-slot (R2 R3 R4 R5 R6)
      sA = ccount + 1;
      n1 = sA + 2*P + 451;
      gen_pass(sA, da, 1, 0, BIG, "R2 R4 R6");
      gen_pass(sA + P, da, 0, 0, BIG, "R3 R5");
      gen_pass(sA + 2*P, da, 0, 0, n1 + 1, "R3");
      pulse(1, 0, da, 0);
      wait_stamp(sA + P + 500);
      digits_i = 20'hFFFFF;            // R6: ignored until next done
      ovr_i    = 1'b1;

      // B: restart mid-slot with new data (R9), refint ignored (R8)
      wait_stamp(n1);
      sB = n1 + 1;
      n2 = sB + 2*P + 120;
      gen_pass(sB, db, 1, 0, BIG, "R9 restart");
      gen_pass(sB + P, db, 0, 0, BIG, "R3 R5");
      gen_pass(sB + 2*P, db, 0, 0, n2 + 1, "R3");
      pulse(1, 0, db, 0);
      wait_stamp(sB + P + 300);
      pulse(0, 1, db, 0);              // R8: no effect while not blanked

      // C: overranged result, blanking, then refint resume (R7)
      wait_stamp(n2);
      sC = n2 + 1;
      gen_pass(sC, dc, 1, 1, BIG, "R7 zero data and blank");
      pulse(1, 0, dc, 1);
      n3 = sC + 902 + 300;
      wait_stamp(n3);
      sR = n3 + 1;
      n4 = sR + P + 50;
      gen_pass(sR, dc, 0, 1, BIG, "R7 resume");
      gen_pass(sR + P, dc, 0, 1, n4 + 1, "R7");
      pulse(0, 1, dc, 1);

      // E: new overranged result while scanning, then done+refint while blanked
      wait_stamp(n4);
      sE = n4 + 1;
      gen_pass(sE, de, 1, 1, BIG, "R7 R9");
      pulse(1, 0, de, 1);
      n5 = sE + 902 + 100;
      wait_stamp(n5);
      sF = n5 + 1;
      gen_pass(sF, df, 1, 0, BIG, "R9 done beats refint");
      gen_pass(sF + P, df, 0, 0, sF + P + 500, "R3 R5");
      pulse(1, 1, df, 0);

      wait_stamp(sF + P + 500);
      chk(exp_q.size() == 0, "R5 all expected changes seen", 10'(exp_q.size()), 10'd0);
      mon_en = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule